// File: doc/BRIEF.md
# Three-Wire Control Bus Slave Receiver

This block is the configuration front end of a stereo audio converter. A host microcontroller writes into it over three wires: a bus clock, a phase line and a serial data line. With the phase line low the host sends an addressing byte, which names a device and one of two register groups. With the phase line high it sends any number of payload bytes. Each payload byte lands in one register, picked by its two top bits. The block presents the resulting settings as parallel fields: sample-clock ratio, serial audio input format, volume code, de-emphasis selection and mute.

All three bus lines are brought into the system clock domain through synchroniser chains. Bits are taken on the rising edge of the synchronised bus clock, most significant bit first. A two-bit strap input can instead select a strap-driven mode. In that mode four application pins set mute, 44.1 kHz de-emphasis and the input format directly, the volume is fixed at 0 dB, and bus traffic has no effect.

Top module: `ctrl3w_slave`

## Requirements
- R1: After reset in bus mode, the outputs read ratio 2'b10 (256fs), format 3'b000 (I2S), volume 6'd0, de-emphasis 2'b00 and mute 0.
- R2: An addressing byte selects the block only when its bits 7:2 equal 6'b000101. Any other address deselects it, and the payload bytes that follow change no output.
- R3: Addressing-byte bits 1:0 pick the group: 2'b00 for sound settings and 2'b10 for status. With 2'b01 or 2'b11, the payload bytes that follow write nothing.
- R4: A selection stays in force for every later payload byte until the next addressing byte.
- R5: A byte is applied only after its eighth bit. A byte cut short by a change of the phase line is dropped.
- R6: In the status group, a payload byte whose bits 7:6 are 2'b00 loads the ratio from bits 5:4 and the format from bits 3:1. Ratio codes: 00 = 512fs, 01 = 384fs, 10 = 256fs. Format codes: 000 = I2S, 001 = LSB-justified 16 bit, 010 = LSB-justified 18 bit, 011 = LSB-justified 20 bit, 100 = MSB-justified. A status byte with any other top field writes nothing.
- R7: In the sound group, top field 2'b00 loads the volume from bits 5:0. Top field 2'b10 loads de-emphasis from bits 4:3 and mute from bit 2. Top fields 2'b01 and 2'b11 write nothing.
- R8: A low phase line marks address bytes and a high one marks payload bytes. Bits are taken on rising bus-clock edges, MSB first, and every transition of the phase line clears the bit count.
- R9: When strap_i is nonzero (strap mode), the outputs are as follows. Mute is app_i[0]. De-emphasis is 2'b10 when app_i[1] is 1, else 2'b00. Format is {1'b0, app_i[2], app_i[3]}. Volume is 0. Ratio is 2'b01 for strap 2'b01 and 2'b10 for strap 2'b10 or 2'b11.
- R10: Bus traffic during strap mode changes no register. On return to bus mode (strap_i = 2'b00), the outputs show the values held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| bus_clk_i | input | 1 | control bus clock, idles high |
| bus_mode_i | input | 1 | phase line: 0 address, 1 payload |
| bus_data_i | input | 1 | serial data, MSB first |
| strap_i | input | 2 | 00 bus mode, 01 strap 384fs, 1x strap 256fs |
| app_i | input | 4 | application pins used in strap mode |
| ratio_o | output | 2 | sample-clock ratio code |
| fmt_o | output | 3 | input format code |
| vol_o | output | 6 | volume attenuation code |
| deemph_o | output | 2 | de-emphasis code |
| mute_o | output | 1 | mute enable |

## Verification
The hardest case to reach from the ports is a byte cut short by a phase-line transition. The bit count must drop the partial bits so that the next full byte is decoded on its own boundary. The stimulus sends four bits in payload phase, toggles the phase line low and back high, and then sends a complete volume byte. Only a correctly cleared count yields the intended volume. Bus writes issued during strap mode are checked the same way: the bench returns to bus mode and compares the retained register values.

// File: rtl/ctrl3w_pkg.sv
package ctrl3w_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 6;

  typedef enum logic [1:0] {
    XF_SOUND  = 2'b00,
    XF_RSVD1  = 2'b01,
    XF_STATUS = 2'b10,
    XF_RSVD3  = 2'b11
  } xfer_e;

  typedef enum logic [1:0] {
    CR_512 = 2'b00,
    CR_384 = 2'b01,
    CR_256 = 2'b10,
    CR_UNK = 2'b11
  } ratio_e;

  typedef struct packed {
    logic [1:0] ratio;
    logic [2:0] fmt;
    logic [5:0] vol;
    logic [1:0] deemph;
    logic       mute;
  } cfg_t;

  localparam cfg_t CFG_RST = '{ratio: CR_256, fmt: 3'b000, vol: 6'd0, deemph: 2'b00, mute: 1'b0};
endpackage

// File: rtl/ctrl3w_sync.sv
module ctrl3w_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ctrl3w_deser.sv
module ctrl3w_deser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              mode_i,
  input  logic              sdat_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              addr_phase_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              sclk_q, mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shr_q;
  logic              rise, mode_edge;

  assign rise      = sclk_i & ~sclk_q;
  assign mode_edge = mode_i ^ mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      mode_q <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      mode_q <= mode_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      shr_q        <= '0;
      byte_vld_o   <= 1'b0;
      byte_o       <= '0;
      addr_phase_o <= 1'b1;
    end else if (mode_edge) begin
      // phase change drops any partial byte
      cnt_q      <= '0;
      byte_vld_o <= 1'b0;
    end else if (rise) begin
      shr_q <= {shr_q[BYTE_W-2:0], sdat_i};
      if (cnt_q == LAST) begin
        cnt_q        <= '0;
        byte_vld_o   <= 1'b1;
        byte_o       <= {shr_q[BYTE_W-2:0], sdat_i};
        addr_phase_o <= ~mode_i;
      end else begin
        cnt_q      <= cnt_q + 1'b1;
        byte_vld_o <= 1'b0;
      end
    end else begin
      byte_vld_o <= 1'b0;
    end
  end

  a_r8_edge_clears_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_edge |=> (cnt_q == '0));
  a_r8_byte_follows_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(rise));
  a_r5_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
endmodule

// File: rtl/ctrl3w_regs.sv
module ctrl3w_regs
  import ctrl3w_pkg::*;
#(
  parameter int                DEV_W    = ADDR_W,
  parameter logic [DEV_W-1:0]  DEV_ADDR = 6'b000101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              addr_phase_i,
  output cfg_t              cfg_o
);
  logic  sel_q;
  xfer_e xfer_q;
  cfg_t  cfg_q;
  logic  pay_vld;

  assign pay_vld = byte_vld_i & bus_en_i & ~addr_phase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      xfer_q <= XF_SOUND;
      cfg_q  <= CFG_RST;
    end else if (byte_vld_i && bus_en_i) begin
      if (addr_phase_i) begin
        sel_q  <= (byte_i[BYTE_W-1 -: DEV_W] == DEV_ADDR);
        xfer_q <= xfer_e'(byte_i[1:0]);
      end else if (sel_q) begin
        unique case (xfer_q)
          XF_SOUND: begin
            if (byte_i[7:6] == 2'b00) cfg_q.vol <= byte_i[5:0];
            else if (byte_i[7:6] == 2'b10) begin
              cfg_q.deemph <= byte_i[4:3];
              cfg_q.mute   <= byte_i[2];
            end
          end
          XF_STATUS: begin
            if (byte_i[7:6] == 2'b00) begin
              cfg_q.ratio <= byte_i[5:4];
              cfg_q.fmt   <= byte_i[3:1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cfg_o = cfg_q;

  a_r10_strap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_en_i |=> $stable(cfg_q));
  a_r2_deselected_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_vld && !sel_q) |=> $stable(cfg_q));
  a_r3_unused_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_vld && xfer_q[0]) |=> $stable(cfg_q));
  a_r6_status_keeps_sound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_vld && xfer_q == XF_STATUS) |=> ($stable(cfg_q.vol) && $stable(cfg_q.mute)));
  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> $stable(cfg_q));
endmodule

// File: rtl/ctrl3w_slave.sv
module ctrl3w_slave
  import ctrl3w_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DEV_ADDR   = 6'b000101
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_clk_i,
  input  logic       bus_mode_i,
  input  logic       bus_data_i,
  input  logic [1:0] strap_i,
  input  logic [3:0] app_i,
  output logic [1:0] ratio_o,
  output logic [2:0] fmt_o,
  output logic [5:0] vol_o,
  output logic [1:0] deemph_o,
  output logic       mute_o
);
  logic [2:0]        sync_q;
  logic              byte_vld, addr_phase, strap_mode;
  logic [BYTE_W-1:0] byte_d;
  cfg_t              reg_cfg, pin_cfg, out_cfg;

  ctrl3w_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bus_clk_i, bus_mode_i, bus_data_i}),
    .q_o   (sync_q)
  );

  ctrl3w_deser #(.BYTE_W(BYTE_W)) u_deser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sync_q[2]),
    .mode_i      (sync_q[1]),
    .sdat_i      (sync_q[0]),
    .byte_vld_o  (byte_vld),
    .byte_o      (byte_d),
    .addr_phase_o(addr_phase)
  );

  assign strap_mode = |strap_i;

  ctrl3w_regs #(.DEV_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_en_i    (~strap_mode),
    .byte_vld_i  (byte_vld),
    .byte_i      (byte_d),
    .addr_phase_i(addr_phase),
    .cfg_o       (reg_cfg)
  );

  always_comb begin
    pin_cfg.ratio  = (strap_i == 2'b01) ? CR_384 : CR_256;
    pin_cfg.fmt    = {1'b0, app_i[2], app_i[3]};
    pin_cfg.vol    = '0;
    pin_cfg.deemph = app_i[1] ? 2'b10 : 2'b00;
    pin_cfg.mute   = app_i[0];
    out_cfg        = strap_mode ? pin_cfg : reg_cfg;
  end

  assign ratio_o  = out_cfg.ratio;
  assign fmt_o    = out_cfg.fmt;
  assign vol_o    = out_cfg.vol;
  assign deemph_o = out_cfg.deemph;
  assign mute_o   = out_cfg.mute;
endmodule

// File: tb/ctrl3w_slave_tb_top.sv
`timescale 1ns/1ps
module ctrl3w_slave_tb_top;
  localparam int HALF = 4;

  typedef struct {
    logic [1:0] ratio;
    logic [2:0] fmt;
    logic [5:0] vol;
    logic [1:0] deemph;
    logic       mute;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b1, bmode = 1'b0, bdat = 1'b0;
  logic [1:0] strap = 2'b00;
  logic [3:0] app = 4'b0000;
  logic [1:0] ratio_o, deemph_o;
  logic [2:0] fmt_o;
  logic [5:0] vol_o;
  logic       mute_o;

  int n_chk = 0, n_fail = 0, pend = 0;
  bit done = 0;
  exp_t exp_q[$];

  // bus-mode register model
  logic       m_sel = 0;
  logic [1:0] m_xfer = 2'b00;
  logic [1:0] m_ratio = 2'b10, m_deem = 2'b00;
  logic [2:0] m_fmt = 3'b000;
  logic [5:0] m_vol = 6'd0;
  logic       m_mute = 1'b0;

  always #2.5 clk = ~clk;

  ctrl3w_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_i(bclk), .bus_mode_i(bmode), .bus_data_i(bdat),
    .strap_i(strap), .app_i(app), .ratio_o(ratio_o), .fmt_o(fmt_o), .vol_o(vol_o),
    .deemph_o(deemph_o), .mute_o(mute_o)
  );

  task automatic bus_bit(input logic b);
    @(negedge clk) bclk = 1'b0; bdat = b;
    repeat (HALF) @(negedge clk);
    bclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk) bmode = m;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
  endtask

  task automatic send_addr(input logic [7:0] a);
    set_mode(1'b0);
    send_byte(a);
    if (strap == 2'b00) begin
      m_sel  = (a[7:2] == 6'b000101);
      m_xfer = a[1:0];
    end
  endtask

  task automatic send_data(input logic [7:0] d);
    set_mode(1'b1);
    send_byte(d);
    if (strap == 2'b00 && m_sel) begin
      if (m_xfer == 2'b00 && d[7:6] == 2'b00) m_vol = d[5:0];
      else if (m_xfer == 2'b00 && d[7:6] == 2'b10) begin m_deem = d[4:3]; m_mute = d[2]; end
      else if (m_xfer == 2'b10 && d[7:6] == 2'b00) begin m_ratio = d[5:4]; m_fmt = d[3:1]; end
    end
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    e.tag = tag;
    if (strap != 2'b00) begin
      e.ratio  = (strap == 2'b01) ? 2'b01 : 2'b10;
      e.fmt    = {1'b0, app[2], app[3]};
      e.vol    = 6'd0;
      e.deemph = app[1] ? 2'b10 : 2'b00;
      e.mute   = app[0];
    end else begin
      e.ratio = m_ratio; e.fmt = m_fmt; e.vol = m_vol; e.deemph = m_deem; e.mute = m_mute;
    end
    exp_q.push_back(e);
    pend++;
    wait (pend == 0);
  endtask

  // monitor: pops expectations once outputs have settled
  initial begin
    exp_t e;
    forever begin
      wait (pend > 0);
      repeat (12) @(negedge clk);
      e = exp_q.pop_front();
      n_chk++;
      if (ratio_o !== e.ratio || fmt_o !== e.fmt || vol_o !== e.vol ||
          deemph_o !== e.deemph || mute_o !== e.mute) begin
        n_fail++;
        $display("FAIL %s: got ratio=%b fmt=%b vol=%0d de=%b mute=%b, exp ratio=%b fmt=%b vol=%0d de=%b mute=%b",
                 e.tag, ratio_o, fmt_o, vol_o, deemph_o, mute_o,
                 e.ratio, e.fmt, e.vol, e.deemph, e.mute);
      end
      pend--;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    expect_now("R1 reset defaults");

    send_addr(8'h16);                   // status group
    send_data(8'b00_00_100_0);
    expect_now("R6 status 512fs MSB-justified");
    send_data(8'b00_01_011_0);
    expect_now("R4 R6 second status byte 384fs LSB20");
    send_data(8'b10_10_001_0);
    expect_now("R6 status top field 10 ignored");

    send_addr(8'h14);                   // sound group
    send_data(8'b00_101010);
    expect_now("R7 volume 42");
    send_data(8'b10_0_11_1_00);
    expect_now("R7 de-emphasis 11 mute 1");
    send_data(8'b01_111111);
    expect_now("R7 top field 01 ignored");
    send_data(8'b11_000001);
    expect_now("R7 top field 11 ignored");

    send_addr(8'b000111_00);
    send_data(8'b00_000001);
    expect_now("R2 foreign address ignored");

    send_addr(8'h15);
    send_data(8'b00_000011);
    expect_now("R3 unused group 01 ignored");
    send_addr(8'h17);
    send_data(8'b00_000101);
    expect_now("R3 unused group 11 ignored");

    send_addr(8'h14);
    set_mode(1'b1);
    for (int i = 0; i < 4; i++) bus_bit(1'b1);
    set_mode(1'b0);
    set_mode(1'b1);
    send_data(8'b00_010001);
    expect_now("R5 R8 partial byte dropped, vol 17");

    strap = 2'b01; app = 4'b0101;
    expect_now("R9 strap 384fs mute LSB18");
    strap = 2'b10; app = 4'b1110;
    expect_now("R9 strap 256fs deemph LSB20");
    send_addr(8'h14);
    send_data(8'b00_000111);
    expect_now("R10 bus ignored in strap mode");
    strap = 2'b00;
    expect_now("R10 registers retained after strap mode");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule